// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Idle-Line Detection

This block is a full-duplex asynchronous serial port for a host bus. A 13-bit divider sets the bit rate: one bit lasts 32 × divider system clocks, and a divider of zero stops the rate generator. The transmitter sends frames of one start bit, eight data bits (least significant first) and one stop bit. The receiver samples the line at sixteen times the bit rate. It checks the start bit at its middle and decides every data and stop bit by a two-of-three vote of the samples around the bit centre.

Two idle-line methods are selectable. In short mode, the count of high bit-times starts at any high sample, including the high tail of a character. In long mode, it starts only after the receiver has finished the stop bit. Idle is reported after ten high bit-times, and only once per period of line activity. A loopback mode routes the transmit stream straight into the receiver and holds the transmit pin high. An open-drain option turns the pin into a pull-low-only driver. Status flags are cleared in two steps: a status read, then a data access. A data read clears the receive flags and a data write clears the transmit flags. Only flags seen by the status read are cleared.

Register map (two-bit address): 0 = divider [12:0]; 1 = control; 2 = status (read only); 3 = data (read gives the received byte, write fills the transmit holding register). Transmit FSM states: TX_IDLE → TX_START (holding register loaded on a tick) → TX_DATA (after 16 ticks) → TX_STOP (after 8 bits) → TX_START if another byte waits, else TX_IDLE. Receive FSM states: RX_IDLE → RX_START (low sample) → RX_IDLE (still high at mid-start, false start) or RX_DATA (after 16 ticks) → RX_STOP (after 8 bits) → RX_IDLE (at the stop vote).

Top module: `uart_idle_xcvr`

## Requirements
- R1: After reset, control reads 0, status reads 0x03 (bit0 transmit-empty = 1, bit1 transmit-complete = 1, all others 0), and the transmit pin drives high (txd_out = 1, txd_oe = 1).
- R2: With divider D > 0 each transmitted bit lasts 32·D clocks; with D = 0 nothing is transmitted.
- R3: A transmitted frame is a low start bit, 8 data bits LSB first, and a high stop bit.
- R4: Status bit0 (transmit-empty) is set when the holding register moves into the shifter. Bit1 (transmit-complete) is set when a frame ends with nothing waiting. Both clear only on a data write that follows a status read showing them set. A data write without that read leaves them set and starts no frame.
- R5: At the end of a received frame, status bit2 (receive-full) sets and the data register returns the byte. The flag clears only on a data read that follows a status read showing it set.
- R6: Status bit4 (framing error) is set when the voted stop bit is low.
- R7: With control bit4 = 0 (short idle), status bit3 sets once the line has been high for 160 sample ticks counted from any high sample.
- R8: With control bit4 = 1 (long idle), the idle count starts only after the stop bit has been sampled, so idle comes later than in short mode.
- R9: With control bits 0 (receive enable), 1 (transmit enable) and 2 (loop) all set, the transmit stream feeds the receiver, the pin stays high, and rxd_pin is ignored. With loop set but receive disabled, the pin transmits normally.
- R10: With control bit3 (open drain) set, txd_out is 0 and txd_oe is 1 only while a low bit is sent, otherwise 0.
- R11: Each interrupt output equals its flag ANDed with its enable: control bit5 transmit-empty, bit6 transmit-complete, bit7 receive-full, bit8 idle.
- R12: A flag that sets after the status read is not cleared by the following data access, and a set in the same cycle as a clear wins.
- R13: A low pulse that is gone by the middle of the start bit is rejected and produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on status/data) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| rxd_pin | input | 1 | Serial receive line |
| txd_out | output | 1 | Transmit pad output value |
| txd_oe | output | 1 | Transmit pad output enable |
| irq_tdre | output | 1 | Transmit-empty interrupt |
| irq_tc | output | 1 | Transmit-complete interrupt |
| irq_rdrf | output | 1 | Receive-full interrupt |
| irq_idle | output | 1 | Idle-line interrupt |

## Verification
Two events can meet in one cycle: a received frame setting receive-full, and the host's data read clearing it. Likewise the transmitter loading its shifter can meet the host's data write. The bench provokes the receive case by reading status while the flag is still clear, letting a frame arrive, and only then reading the data register. The flag must survive that read and must clear only after a fresh status read is followed by a second data read. The design lets a set win over a clear in the same cycle.

// File: rtl/uidl_pkg.sv
package uidl_pkg;
    localparam int DIV_W      = 13;
    localparam int DATA_W     = 8;
    localparam int OVS        = 16;
    localparam int FRAME_BITS = 10;
    localparam int REG_W      = 16;

    localparam logic [1:0] A_DIV  = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uidl_baud.sv
module uidl_baud #(
    parameter int DIV_W = uidl_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim = {div_i, 1'b0} - CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (div_i == '0) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= lim) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + CW'(1);
            tick_o <= 1'b0;
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    // R2
    tick_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(div_i == '0) |-> !tick_o);
endmodule

// File: rtl/uidl_tx.sv
module uidl_tx
    import uidl_pkg::*;
#(
    parameter int DATA_W = uidl_pkg::DATA_W,
    parameter int OVS    = uidl_pkg::OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              have_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              load_o,
    output logic              done_o,
    output logic              ser_o
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W);

    tx_state_t         state_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              last;
    logic              can;

    assign last   = (cnt_q == CW'(OVS - 1));
    assign can    = en_i && have_i;
    assign load_o = tick_i && can &&
                    (state_q == TX_IDLE || (state_q == TX_STOP && last));
    assign done_o = tick_i && !can && state_q == TX_STOP && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else if (tick_i) begin
            unique case (state_q)
                TX_IDLE: begin
                    cnt_q <= '0;
                    if (load_o) begin
                        state_q <= TX_START;
                        sh_q    <= data_i;
                    end
                end
                TX_START: begin
                    cnt_q <= last ? '0 : cnt_q + CW'(1);
                    if (last) begin
                        state_q <= TX_DATA;
                        idx_q   <= '0;
                    end
                end
                TX_DATA: begin
                    cnt_q <= last ? '0 : cnt_q + CW'(1);
                    if (last) begin
                        sh_q  <= sh_q >> 1;
                        idx_q <= idx_q + IW'(1);
                        if (idx_q == IW'(DATA_W - 1)) state_q <= TX_STOP;
                    end
                end
                TX_STOP: begin
                    cnt_q <= last ? '0 : cnt_q + CW'(1);
                    if (last) begin
                        if (load_o) begin
                            state_q <= TX_START;
                            sh_q    <= data_i;
                        end else begin
                            state_q <= TX_IDLE;
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START: ser_o = 1'b0;
            TX_DATA:  ser_o = sh_q[0];
            default:  ser_o = 1'b1;
        endcase
    end

    // R2
    tx_tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(tick_i));
endmodule

// File: rtl/uidl_rx.sv
module uidl_rx
    import uidl_pkg::*;
#(
    parameter int DATA_W     = uidl_pkg::DATA_W,
    parameter int OVS        = uidl_pkg::OVS,
    parameter int FRAME_BITS = uidl_pkg::FRAME_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              long_i,
    input  logic              rx_i,
    output logic              done_o,
    output logic              stop_o,
    output logic [DATA_W-1:0] data_o,
    output logic              idle_o
);
    localparam int CW     = $clog2(OVS);
    localparam int IW     = $clog2(DATA_W);
    localparam int MID    = OVS / 2 - 1;
    localparam int IDLE_T = FRAME_BITS * OVS;
    localparam int ICW    = $clog2(IDLE_T + 1);

    rx_state_t         state_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] sh_q;
    logic [1:0]        smp_q;
    logic [ICW-1:0]    icnt_q;
    logic              armed_q;
    logic              last;
    logic              vote;

    assign last   = (cnt_q == CW'(OVS - 1));
    assign vote   = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_i) | (smp_q[1] & rx_i);
    assign data_o = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            smp_q   <= '0;
            icnt_q  <= '0;
            armed_q <= 1'b0;
            done_o  <= 1'b0;
            stop_o  <= 1'b1;
            idle_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            idle_o <= 1'b0;
            if (!en_i) begin
                state_q <= RX_IDLE;
                cnt_q   <= '0;
                icnt_q  <= '0;
                armed_q <= 1'b0;
            end else if (tick_i) begin
                unique case (state_q)
                    RX_IDLE: begin
                        cnt_q <= '0;
                        if (!rx_i) state_q <= RX_START;
                    end
                    RX_START: begin
                        cnt_q <= last ? '0 : cnt_q + CW'(1);
                        if (cnt_q == CW'(MID) && rx_i) begin
                            state_q <= RX_IDLE;
                        end else if (last) begin
                            state_q <= RX_DATA;
                            idx_q   <= '0;
                        end
                    end
                    RX_DATA: begin
                        cnt_q <= last ? '0 : cnt_q + CW'(1);
                        if (cnt_q == CW'(MID))     smp_q[0] <= rx_i;
                        if (cnt_q == CW'(MID + 1)) smp_q[1] <= rx_i;
                        if (cnt_q == CW'(MID + 2)) sh_q <= {vote, sh_q[DATA_W-1:1]};
                        if (last) begin
                            idx_q <= idx_q + IW'(1);
                            if (idx_q == IW'(DATA_W - 1)) state_q <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        cnt_q <= cnt_q + CW'(1);
                        if (cnt_q == CW'(MID))     smp_q[0] <= rx_i;
                        if (cnt_q == CW'(MID + 1)) smp_q[1] <= rx_i;
                        if (cnt_q == CW'(MID + 2)) begin
                            done_o  <= 1'b1;
                            stop_o  <= vote;
                            state_q <= RX_IDLE;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase

                if (!rx_i) begin
                    icnt_q  <= '0;
                    armed_q <= 1'b1;
                end else if (long_i && state_q != RX_IDLE) begin
                    icnt_q <= '0;
                end else if (icnt_q != ICW'(IDLE_T)) begin
                    icnt_q <= icnt_q + ICW'(1);
                    if (icnt_q == ICW'(IDLE_T - 1) && armed_q) begin
                        idle_o  <= 1'b1;
                        armed_q <= 1'b0;
                    end
                end
            end
        end
    end

    // R5
    rx_done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    rx_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> $past(rx_i));
endmodule

// File: rtl/uart_idle_xcvr.sv
module uart_idle_xcvr
    import uidl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             rxd_pin,
    output logic             txd_out,
    output logic             txd_oe,
    output logic             irq_tdre,
    output logic             irq_tc,
    output logic             irq_rdrf,
    output logic             irq_idle
);
    localparam int CTRL_W = 9;
    localparam int STAT_W = 5;

    logic [DIV_W-1:0]  div_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] tdr_q, rdr_q;
    logic              tdre_q, tc_q, rdrf_q, idle_q, fe_q;
    logic [STAT_W-1:0] seen_q, status;
    logic [1:0]        rx_sync_q;
    logic              tick, tx_load, tx_done, tx_ser;
    logic              rx_done, rx_stop, rx_idle, rx_src;
    logic [DATA_W-1:0] rx_data;
    logic              loop_act, pin_hi;
    logic              stat_rd, data_rd, data_wr;
    logic              unused_wdata;

    assign unused_wdata = &{1'b0, reg_wdata[REG_W-1:DIV_W]};

    assign status  = {fe_q, idle_q, rdrf_q, tc_q, tdre_q};
    assign stat_rd = reg_rd && reg_addr == A_STAT;
    assign data_rd = reg_rd && reg_addr == A_DATA;
    assign data_wr = reg_wr && reg_addr == A_DATA;

    assign loop_act = ctrl_q[2] && ctrl_q[1] && ctrl_q[0];
    assign rx_src   = loop_act ? tx_ser : rx_sync_q[1];
    assign pin_hi   = loop_act || tx_ser;
    assign txd_out  = ctrl_q[3] ? 1'b0 : pin_hi;
    assign txd_oe   = ctrl_q[3] ? !pin_hi : 1'b1;

    assign irq_tdre = tdre_q && ctrl_q[5];
    assign irq_tc   = tc_q   && ctrl_q[6];
    assign irq_rdrf = rdrf_q && ctrl_q[7];
    assign irq_idle = idle_q && ctrl_q[8];

    always_comb begin
        unique case (reg_addr)
            A_DIV:   reg_rdata = {{(REG_W-DIV_W){1'b0}}, div_q};
            A_CTRL:  reg_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
            A_STAT:  reg_rdata = {{(REG_W-STAT_W){1'b0}}, status};
            default: reg_rdata = {{(REG_W-DATA_W){1'b0}}, rdr_q};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= '0;
            ctrl_q    <= '0;
            tdr_q     <= '0;
            rdr_q     <= '0;
            tdre_q    <= 1'b1;
            tc_q      <= 1'b1;
            rdrf_q    <= 1'b0;
            idle_q    <= 1'b0;
            fe_q      <= 1'b0;
            seen_q    <= '0;
            rx_sync_q <= 2'b11;
        end else begin
            rx_sync_q <= {rx_sync_q[0], rxd_pin};
            if (reg_wr && reg_addr == A_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
            if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
            if (data_wr) tdr_q <= reg_wdata[DATA_W-1:0];
            if (rx_done) rdr_q <= rx_data;

            if (tx_load)                   tdre_q <= 1'b1;
            else if (data_wr && seen_q[0]) tdre_q <= 1'b0;
            if (tx_done)                   tc_q <= 1'b1;
            else if (data_wr && seen_q[1]) tc_q <= 1'b0;
            if (rx_done)                   rdrf_q <= 1'b1;
            else if (data_rd && seen_q[2]) rdrf_q <= 1'b0;
            if (rx_idle)                   idle_q <= 1'b1;
            else if (data_rd && seen_q[3]) idle_q <= 1'b0;
            if (rx_done && !rx_stop)       fe_q <= 1'b1;
            else if (data_rd && seen_q[4]) fe_q <= 1'b0;

            if (stat_rd)      seen_q      <= status;
            else if (data_rd) seen_q[4:2] <= '0;
            else if (data_wr) seen_q[1:0] <= '0;
        end
    end

    uidl_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .div_i(div_q), .tick_o(tick)
    );

    uidl_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(ctrl_q[1]),
        .have_i(!tdre_q), .data_i(tdr_q), .load_o(tx_load),
        .done_o(tx_done), .ser_o(tx_ser)
    );

    uidl_rx #(.DATA_W(DATA_W), .OVS(OVS), .FRAME_BITS(FRAME_BITS)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(ctrl_q[0]),
        .long_i(ctrl_q[4]), .rx_i(rx_src), .done_o(rx_done),
        .stop_o(rx_stop), .data_o(rx_data), .idle_o(rx_idle)
    );

    // R4
    tdre_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tdre_q) |-> $past(data_wr));
    // R5
    rdrf_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdrf_q) |-> $past(rx_done));
    // R9
    loop_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_act && !ctrl_q[3]) |-> txd_out);
    // R10
    od_no_drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[3] |-> !(txd_oe && txd_out));
endmodule

// File: tb/uart_idle_xcvr_tb_top.sv
module uart_idle_xcvr_tb_top;
    localparam int DIV = 2;
    localparam int BIT = 32 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        line = 1'b1;
    logic        txd_out, txd_oe, irq_tdre, irq_tc, irq_rdrf, irq_idle;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    uart_idle_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rxd_pin(line), .txd_out(txd_out), .txd_oe(txd_oe),
        .irq_tdre(irq_tdre), .irq_tc(irq_tc), .irq_rdrf(irq_rdrf),
        .irq_idle(irq_idle)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; line = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop);
        @(negedge clk);
        line = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            line = b[i];
            repeat (BIT) @(negedge clk);
        end
        line = stop;
        repeat (BIT) @(negedge clk);
        line = 1'b1;
    endtask

    task automatic arm_write(input logic [7:0] b);
        logic [15:0] v;
        rd(2'd2, v);
        wr(2'd3, {8'h00, b});
    endtask

    task automatic wait_low(input int limit, output int seen);
        seen = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (txd_out == 1'b0) begin seen = 1; break; end
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(2'd1, v); chk("R1 ctrl", v, 0);
        rd(2'd2, v); chk("R1 status", v, 16'h0003);
        chk("R1 txd_out", txd_out, 1);
        chk("R1 txd_oe", txd_oe, 1);
        chk("R11 irq_tdre off", irq_tdre, 0);
        wr(2'd1, 16'h0060);
        @(negedge clk);
        chk("R11 irq_tdre on", irq_tdre, 1);
        chk("R11 irq_tc on", irq_tc, 1);
        chk("R11 irq_rdrf off", irq_rdrf, 0);
    endtask

    task automatic t_no_arm();
        logic [15:0] v;
        int low;
        do_reset();
        wr(2'd0, DIV); wr(2'd1, 16'h0002);
        wr(2'd3, 16'h0011);
        wait_low(300, low);
        chk("R4 no frame without status read", low, 0);
        rd(2'd2, v); chk("R4 tdre stays set", v[0], 1);
    endtask

    task automatic t_tx_frame();
        logic [15:0] v;
        logic [7:0] got;
        int low, dur;
        do_reset();
        wr(2'd0, DIV); wr(2'd1, 16'h0002);
        arm_write(8'hA5);
        wait_low(200, low);
        chk("R3 start bit seen", low, 1);
        dur = 0;
        while (txd_out == 1'b0 && dur < 1000) begin dur++; @(negedge clk); end
        chk("R2 bit length", dur, BIT);
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            got[i] = txd_out;
            repeat (BIT) @(negedge clk);
        end
        chk("R3 data LSB first", got, 8'hA5);
        chk("R3 stop bit", txd_out, 1);
        repeat (BIT) @(negedge clk);
        rd(2'd2, v); chk("R4 tdre and tc set", v[1:0], 2'b11);
    endtask

    task automatic t_div0();
        logic [15:0] v;
        int low;
        do_reset();
        wr(2'd1, 16'h0002);
        arm_write(8'h00);
        wait_low(1000, low);
        chk("R2 zero divider sends nothing", low, 0);
        rd(2'd2, v); chk("R2 tdre stays clear", v[0], 0);
    endtask

    task automatic t_rx();
        logic [15:0] v;
        do_reset();
        wr(2'd0, DIV); wr(2'd1, 16'h0081);
        rd(2'd2, v);
        send_frame(8'h3C, 1'b1);
        repeat (32) @(negedge clk);
        rd(2'd3, v); chk("R5 received byte", v, 16'h003C);
        rd(2'd2, v); chk("R12 rdrf survives early-armed read", v[2], 1);
        chk("R11 irq_rdrf", irq_rdrf, 1);
        chk("R6 no framing error", v[4], 0);
        rd(2'd3, v);
        rd(2'd2, v); chk("R5 rdrf cleared by sequence", v[2], 0);
    endtask

    task automatic t_fe();
        logic [15:0] v;
        do_reset();
        wr(2'd0, DIV); wr(2'd1, 16'h0001);
        send_frame(8'h55, 1'b0);
        repeat (32) @(negedge clk);
        rd(2'd2, v);
        chk("R6 framing error", v[4], 1);
        chk("R6 rdrf with error", v[2], 1);
    endtask

    task automatic t_false_start();
        logic [15:0] v;
        do_reset();
        wr(2'd0, DIV); wr(2'd1, 16'h0001);
        @(negedge clk);
        line = 1'b0;
        repeat (12) @(negedge clk);
        line = 1'b1;
        repeat (1400) @(negedge clk);
        rd(2'd2, v); chk("R13 glitch rejected", v[2], 0);
    endtask

    task automatic t_idle(input logic long_m);
        logic [15:0] v;
        do_reset();
        wr(2'd0, DIV); wr(2'd1, {11'd0, long_m, 4'b0001});
        send_frame(8'hFF, 1'b1);
        repeat (260) @(negedge clk);
        rd(2'd2, v);
        if (long_m) chk("R8 long idle not yet", v[3], 0);
        else        chk("R7 short idle set", v[3], 1);
        repeat (500) @(negedge clk);
        rd(2'd2, v);
        if (long_m) chk("R8 long idle set", v[3], 1);
        else        chk("R7 short idle held", v[3], 1);
    endtask

    task automatic t_loop();
        logic [15:0] v;
        int high_ok, low;
        do_reset();
        wr(2'd0, DIV); wr(2'd1, 16'h0007);
        line = 1'b0;
        arm_write(8'h5A);
        high_ok = 1;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (txd_out != 1'b1) high_ok = 0;
        end
        chk("R9 pin held high", high_ok, 1);
        rd(2'd2, v); chk("R9 looped frame received", v[2], 1);
        rd(2'd3, v); chk("R9 looped byte", v, 16'h005A);
        line = 1'b1;
        wr(2'd1, 16'h0006);
        arm_write(8'h33);
        wait_low(300, low);
        chk("R9 loop needs receive enable", low, 1);
    endtask

    task automatic t_od();
        int got;
        do_reset();
        wr(2'd0, DIV); wr(2'd1, 16'h000A);
        @(negedge clk);
        chk("R10 released when idle", txd_oe, 0);
        arm_write(8'h00);
        got = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd_oe) begin got = 1; break; end
        end
        chk("R10 drives during low", got, 1);
        chk("R10 drives low value", txd_out, 0);
        repeat (800) @(negedge clk);
        chk("R10 released after frame", txd_oe, 0);
    endtask

    initial begin
        t_reset();
        t_no_arm();
        t_tx_frame();
        t_div0();
        t_rx();
        t_fe();
        t_false_start();
        t_idle(1'b0);
        t_idle(1'b1);
        t_loop();
        t_od();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule